// File: doc/BRIEF.md
# NR4SD coefficient digit encoder

This block rewrites a two's-complement coefficient of `WIDTH` bits as a string of radix-4 signed digits. The result is meant to be computed ahead of time and written into the coefficient store of a pre-encoded multiplier. Every digit below the top one takes only four values, -2, -1, 0 and +1, so it fits in two bits. This keeps the partial-product selectors in the multiplier simpler than a five-value Booth selector.

The digits come from a carry ripple that runs from the least significant bit pair upward. For each pair, an ordinary half adder folds the incoming carry into the even bit. A second half adder, whose sum output counts negatively, then absorbs the odd bit. The carry left at the top enters the most significant digit. That digit uses the full five-value Booth set, so the whole two's-complement range stays representable, and it is stored as a sign and two magnitude flags.

The encoder is combinational internally. A coefficient presented with `in_valid` is registered, and its digit word appears on the next cycle together with `out_valid`.

Top module: `nr4sd_coef_encoder`

## Requirements
- R1: While `rst_n` is low, `out_valid` is 0 and `digits` is all zeros.
- R2: `out_valid` equals the value of `in_valid` sampled at the previous rising clock edge (one cycle of latency).
- R3: When `in_valid` is low at a rising edge, `digits` keeps its previous value, whatever `coef` carries.
- R4: For each low digit j, with 0 <= j < WIDTH/2-1, bits [2j+1:2j] of `digits` hold the digit. Bit 2j+1 has weight -2 and bit 2j has weight +1, so the digit value lies in {-2,-1,0,+1} and equals -2*bit(2j+1) + bit(2j).
- R5: The carry into digit 0 is 0. For digit j, the even sum is b(2j) XOR c and the middle carry is b(2j) AND c, where c is the carry into that digit. The odd (negative) sum is b(2j+1) XOR middle carry, and the carry out is b(2j+1) OR middle carry. Together these satisfy 2*carry_out - odd_sum = b(2j+1) + middle carry.
- R6: Bits [WIDTH:WIDTH-2] of `digits` hold the top digit as {neg, mag2, mag1}. Its value is -2*b(WIDTH-1) + b(WIDTH-2) + c, where c is the carry out of the highest low digit. The value is (neg ? -1 : +1) * (2*mag2 + mag1). mag2 and mag1 are never both set, and neg is set only when the value is nonzero.
- R7: The sum over all digits of digit value times 4^j equals the signed value of the registered `coef`, for every input.
- R8: `WIDTH` is even and at least 4, and `digits` is `WIDTH+1` bits wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Load `coef` into the output register |
| coef | input | WIDTH | Two's-complement coefficient |
| out_valid | output | 1 | `digits` holds a freshly encoded coefficient |
| digits | output | WIDTH+1 | Packed signed-digit word, least significant digit in the lowest bits |

## Verification
The bench builds two instances, one with `WIDTH` = 8 and one with `WIDTH` = 12. At both widths every coefficient value is swept exhaustively. This covers the full 256-value range and the full 4096-value range, so every carry pattern reaches the top digit, including the cases where the carry turns the most negative input or an all-ones low part into a -2 or +2 top digit. Idle cycles with a changing `coef` are interleaved to exercise the hold behaviour at both widths.

// File: rtl/nr4sd_pkg.sv
package nr4sd_pkg;

  // Top digit code: sign plus one-hot-or-zero magnitude.
  typedef struct packed {
    logic neg;
    logic mag2;
    logic mag1;
  } msd_code_t;

  // Plain half adder, returns {carry, sum}; sum carries weight +1.
  function automatic logic [1:0] half_add(input logic a, input logic b);
    return {a & b, a ^ b};
  endfunction

  // Half adder whose sum carries weight -1: 2*carry - sum = a + b.
  function automatic logic [1:0] half_add_negsum(input logic a, input logic b);
    return {a | b, a ^ b};
  endfunction

  // Top digit: value = -2*top + nxt + cin, range -2..+2.
  function automatic msd_code_t booth_msd(input logic top, input logic nxt,
                                          input logic cin);
    logic [1:0] low;
    msd_code_t  r;
    low = {1'b0, nxt} + {1'b0, cin};
    r   = '0;
    if (!top) begin
      r.mag1 = (low == 2'd1);
      r.mag2 = (low == 2'd2);
    end else begin
      r.neg  = (low != 2'd2);
      r.mag2 = (low == 2'd0);
      r.mag1 = (low == 2'd1);
    end
    return r;
  endfunction

endpackage

// File: rtl/nr4sd_lo_cell.sv
module nr4sd_lo_cell (
  input  logic b_even,
  input  logic b_odd,
  input  logic c_in,
  output logic n_even,
  output logic n_odd,
  output logic c_mid,
  output logic c_out
);
  logic [1:0] lo_pair;
  logic [1:0] hi_pair;

  assign lo_pair = nr4sd_pkg::half_add(b_even, c_in);
  assign n_even  = lo_pair[0];
  assign c_mid   = lo_pair[1];

  assign hi_pair = nr4sd_pkg::half_add_negsum(b_odd, c_mid);
  assign n_odd   = hi_pair[0];
  assign c_out   = hi_pair[1];
endmodule

// File: rtl/nr4sd_msd_enc.sv
module nr4sd_msd_enc (
  input  logic                  b_top,
  input  logic                  b_next,
  input  logic                  c_in,
  output nr4sd_pkg::msd_code_t  code
);
  assign code = nr4sd_pkg::booth_msd(b_top, b_next, c_in);
endmodule

// File: rtl/nr4sd_chain.sv
module nr4sd_chain #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] coef,
  output logic [WIDTH:0]   word,
  output logic [WIDTH/2-2:0] c_in_v,
  output logic [WIDTH/2-2:0] c_mid_v,
  output logic [WIDTH/2-2:0] n_even_v,
  output logic [WIDTH/2-2:0] n_odd_v,
  output logic [WIDTH/2-2:0] c_out_v
);
  localparam int NLO = WIDTH/2 - 1;

  logic [NLO:0]          carry;
  nr4sd_pkg::msd_code_t  msd;

  assign carry[0] = 1'b0;

  for (genvar j = 0; j < NLO; j++) begin : g_lo
    nr4sd_lo_cell u_cell (
      .b_even (coef[2*j]),
      .b_odd  (coef[2*j+1]),
      .c_in   (carry[j]),
      .n_even (n_even_v[j]),
      .n_odd  (n_odd_v[j]),
      .c_mid  (c_mid_v[j]),
      .c_out  (carry[j+1])
    );
    assign word[2*j+1:2*j] = {n_odd_v[j], n_even_v[j]};
  end

  nr4sd_msd_enc u_msd (
    .b_top  (coef[WIDTH-1]),
    .b_next (coef[WIDTH-2]),
    .c_in   (carry[NLO]),
    .code   (msd)
  );
  assign word[WIDTH:WIDTH-2] = msd;

  assign c_in_v  = carry[NLO-1:0];
  assign c_out_v = carry[NLO:1];
endmodule

// File: rtl/nr4sd_coef_encoder.sv
module nr4sd_coef_encoder #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [WIDTH-1:0] coef,
  output logic             out_valid,
  output logic [WIDTH:0]   digits
);
  localparam int NLO   = WIDTH/2 - 1;
  localparam int OUT_W = 2*NLO + 3;

  if (WIDTH < 4 || (WIDTH % 2) != 0 || OUT_W != WIDTH + 1) begin : g_bad_width
    $error("nr4sd_coef_encoder: WIDTH must be even and at least 4");
  end

  logic [WIDTH:0] enc_word;
  logic [NLO-1:0] lo_c_in;
  logic [NLO-1:0] lo_c_mid;
  logic [NLO-1:0] lo_n_even;
  logic [NLO-1:0] lo_n_odd;
  logic [NLO-1:0] lo_c_out;

  nr4sd_chain #(.WIDTH(WIDTH)) u_chain (
    .coef     (coef),
    .word     (enc_word),
    .c_in_v   (lo_c_in),
    .c_mid_v  (lo_c_mid),
    .n_even_v (lo_n_even),
    .n_odd_v  (lo_n_odd),
    .c_out_v  (lo_c_out)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      digits    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) digits <= enc_word;
    end
  end
endmodule

// File: rtl/nr4sd_coef_encoder_chk.sv
module nr4sd_coef_encoder_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic [WIDTH-1:0] coef,
  input logic             out_valid,
  input logic [WIDTH:0]   digits,
  input logic [WIDTH/2-2:0] c_even,
  input logic [WIDTH/2-2:0] c_mid,
  input logic [WIDTH/2-2:0] n_even,
  input logic [WIDTH/2-2:0] n_odd,
  input logic [WIDTH/2-2:0] c_next
);
  localparam int NLO = WIDTH/2 - 1;

  function automatic longint decode_word(input logic [WIDTH:0] w);
    longint acc;
    longint scale;
    longint top;
    acc   = 0;
    scale = 1;
    for (int j = 0; j < NLO; j++) begin
      acc   = acc + scale * (longint'(w[2*j]) - 2 * longint'(w[2*j+1]));
      scale = scale * 4;
    end
    top = 2 * longint'(w[WIDTH-1]) + longint'(w[WIDTH-2]);
    if (w[WIDTH]) top = -top;
    return acc + scale * top;
  endfunction

  // R1: reset clears the output register
  a_r1_reset_clear: assert property (@(posedge clk)
    !rst_n |=> (!out_valid && digits == '0));

  // R2: valid follows input valid by one cycle
  a_r2_valid_follow: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r2_valid_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  // R3: no load without in_valid
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && $past(rst_n)) |=> $stable(digits));

  // R6: top digit code legal
  a_r6_msd_legal: assert property (@(posedge clk) disable iff (!rst_n)
    !(digits[WIDTH-1] && digits[WIDTH-2]) &&
    (!digits[WIDTH] || digits[WIDTH-1] || digits[WIDTH-2]));

  // R7: decoded digits equal the registered coefficient
  a_r7_value: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> decode_word(digits) == longint'($signed($past(coef))));

  // R5: carry chain relations at every pair
  always_comb begin
    if (rst_n) begin
      a_r5_first_carry: assert (c_even[0] == 1'b0);
      for (int j = 0; j < NLO; j++) begin
        a_r5_even_balance: assert (2 * int'(c_mid[j]) + int'(n_even[j]) ==
                                   int'(coef[2*j]) + int'(c_even[j]));
        a_r5_odd_balance: assert (2 * int'(c_next[j]) - int'(n_odd[j]) ==
                                  int'(coef[2*j+1]) + int'(c_mid[j]));
        if (j > 0) begin
          a_r5_ripple: assert (c_even[j] == c_next[j-1]);
        end
      end
    end
  end
endmodule

bind nr4sd_coef_encoder nr4sd_coef_encoder_chk #(.WIDTH(WIDTH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .coef      (coef),
  .out_valid (out_valid),
  .digits    (digits),
  .c_even    (lo_c_in),
  .c_mid     (lo_c_mid),
  .n_even    (lo_n_even),
  .n_odd     (lo_n_odd),
  .c_next    (lo_c_out)
);

// File: tb/nr4sd_coef_encoder_bench.sv
`timescale 1ns/1ps
module nr4sd_coef_encoder_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [7:0]  coef8;
  logic [11:0] coef12;
  logic        ov8, ov12;
  logic [8:0]  dig8;
  logic [12:0] dig12;

  int checks = 0;
  int fails  = 0;

  // reference model state
  logic        m_valid8, m_valid12;
  logic [31:0] m_word8, m_word12;
  int          m_val8, m_val12;

  always #5 clk = ~clk;

  nr4sd_coef_encoder #(.WIDTH(8)) u_nr4sd_coef_encoder (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .coef(coef8),
    .out_valid(ov8), .digits(dig8));

  nr4sd_coef_encoder #(.WIDTH(12)) u_nr4sd_coef_encoder_w12 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .coef(coef12),
    .out_valid(ov12), .digits(dig12));

  // Behavioural reference: integer carry arithmetic, digit by digit
  function automatic logic [31:0] ref_encode(input int w, input int b);
    int c, t, u, ne, no, v, mag;
    logic [31:0] word;
    c = 0; word = '0;
    for (int j = 0; j < w/2 - 1; j++) begin
      t  = ((b >> (2*j)) & 1) + c;
      ne = t % 2;
      u  = ((b >> (2*j+1)) & 1) + t / 2;
      no = u % 2;
      c  = (u + 1) / 2;
      word[2*j]   = ne[0];
      word[2*j+1] = no[0];
    end
    v   = -2 * ((b >> (w-1)) & 1) + ((b >> (w-2)) & 1) + c;
    mag = (v < 0) ? -v : v;
    word[w]   = (v < 0);
    word[w-1] = (mag == 2);
    word[w-2] = (mag == 1);
    return word;
  endfunction

  function automatic int ref_decode(input int w, input logic [31:0] word);
    int acc, scale, top;
    acc = 0; scale = 1;
    for (int j = 0; j < w/2 - 1; j++) begin
      acc   = acc + scale * (int'(word[2*j]) - 2 * int'(word[2*j+1]));
      scale = scale * 4;
    end
    top = 2 * int'(word[w-1]) + int'(word[w-2]);
    if (word[w]) top = -top;
    return acc + scale * top;
  endfunction

  function automatic int to_signed(input int w, input int b);
    return (b >= (1 << (w-1))) ? b - (1 << w) : b;
  endfunction

  task automatic check(input bit ok, input string req, input longint act,
                       input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    // R2 valid latency, R3/R4/R5/R6 exact word, R7 decoded value
    check(ov8 == m_valid8, "R2 w8", ov8, m_valid8);
    check(ov12 == m_valid12, "R2 w12", ov12, m_valid12);
    check(dig8 == m_word8[8:0], "R4 R5 R3 w8 word", dig8, m_word8[8:0]);
    check(dig12 == m_word12[12:0], "R4 R5 R3 w12 word", dig12, m_word12[12:0]);
    check(!(dig8[7] && dig8[6]) && (!dig8[8] || dig8[7] || dig8[6]),
          "R6 w8 top code", dig8[8:6], 0);
    check(!(dig12[11] && dig12[10]) && (!dig12[12] || dig12[11] || dig12[10]),
          "R6 w12 top code", dig12[12:10], 0);
    if (m_valid8)
      check(ref_decode(8, {23'b0, dig8}) == m_val8, "R7 w8 value",
            ref_decode(8, {23'b0, dig8}), m_val8);
    if (m_valid12)
      check(ref_decode(12, {19'b0, dig12}) == m_val12, "R7 w12 value",
            ref_decode(12, {19'b0, dig12}), m_val12);
  endtask

  // One cycle: check outputs, advance the model, drive the next inputs
  task automatic step(input bit v, input int c8, input int c12);
    @(negedge clk);
    compare_all();
    if (rst_n) begin
      m_valid8  = v;
      m_valid12 = v;
      if (v) begin
        m_word8  = ref_encode(8, c8);
        m_word12 = ref_encode(12, c12);
        m_val8   = to_signed(8, c8);
        m_val12  = to_signed(12, c12);
      end
    end
    in_valid = v;
    coef8    = c8[7:0];
    coef12   = c12[11:0];
  endtask

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b1; coef8 = 8'hA5; coef12 = 12'h5A5;
    m_valid8 = 0; m_valid12 = 0; m_word8 = '0; m_word12 = '0;
    m_val8 = 0; m_val12 = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state with in_valid held high
    check(ov8 == 1'b0 && dig8 == '0, "R1 w8 reset", dig8, 0);
    check(ov12 == 1'b0 && dig12 == '0, "R1 w12 reset", dig12, 0);
    // R8: output width
    check($bits(dig8) == 9, "R8 w8 width", $bits(dig8), 9);
    check($bits(dig12) == 13, "R8 w12 width", $bits(dig12), 13);
    rst_n = 1'b1;
    in_valid = 1'b0;
    // corner values: zero, most negative, most positive, all ones
    step(1, 0, 0);
    step(1, 128, 2048);
    step(1, 127, 2047);
    step(1, 255, 4095);
    step(1, 85, 1365);
    step(1, 170, 2730);
    // R3: idle cycles with changing coef
    step(0, 17, 999);
    step(0, 200, 3000);
    // exhaustive sweep of both widths with idle gaps
    for (int i = 0; i < 4096; i++) begin
      step(1, i & 255, i);
      if ((i % 7) == 3) step(0, (i * 31) & 255, (i * 13) & 4095);
    end
    step(0, 0, 0);
    step(0, 0, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule